// File: doc/BRIEF.md
# Closed-Loop Voltage Margining Controller

This block trims a power supply's output voltage by driving a PWM pin whose filtered level is summed into the supply's feedback node. It reads output-voltage codes from an ADC interface and compares each valid sample directly against a target code of the same resolution. It then moves the PWM duty cycle one step at a time until the measured code lies inside a programmable deadband around the target.

A margin request selects the low or the high target. When no request is active, the pin follows one of four idle behaviours picked by a 2-bit mode input: off, high impedance, active trim to a nominal target, or a fixed programmed duty. A polarity bit sets whether more duty raises or lowers the supply voltage. A settled flag reports that enough consecutive samples have landed inside the deadband.

Top module: `vmarg_ctrl`

## Requirements
- R1: While reset is high and on the first cycles after it, pwm_oe, pwm_out and settled are all 0.
- R2: The PWM period is 256 clocks. In each period pwm_out is high for exactly duty clocks, so duty 0 gives a pin that is always low and duty 255 gives 255 high clocks out of 256. A new duty takes effect only at a period boundary.
- R3: While regulating with margin_req = 1 (low, target tgt_lo) or margin_req = 2 (high, target tgt_hi) in a mode other than 0, each sample with adc_valid high moves the duty by one step. A sample above target+deadband moves it in the direction that lowers the voltage, and a sample below target-deadband moves it in the direction that raises the voltage. A sample inside the band leaves the duty unchanged.
- R4: With invert = 0, more duty raises the voltage, so a sample below the band adds 1. With invert = 1 the step direction is reversed.
- R5: The duty saturates at 255 going up and at 0 going down.
- R6: In mode 0 (off), requests and samples are ignored: pwm_oe and pwm_out stay 0 and settled stays 0.
- R7: In mode 1 (high impedance), pwm_oe is 0 while margin_req is 0 or 3 (none), and 1 while margining.
- R8: In mode 2 (trim) with no request, the duty is regulated toward tgt_nom by the rule of R3, and pwm_oe is 1.
- R9: In mode 3 (fixed) with no request, the duty equals fixed_duty, samples are ignored, and pwm_oe is 1.
- R10: A margin request entered from a non-regulating state starts stepping from fixed_duty. A request entered from active trim continues from the trimmed duty.
- R11: settled rises on the clock edge that accepts the 4th consecutive in-band sample (SETTLE_CNT) while regulating. An out-of-band sample clears it on the edge that accepts that sample.
- R12: Any change of mode or request clears settled and the in-band count on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | 0 off, 1 high impedance, 2 trim, 3 fixed |
| cfg_invert | input | 1 | 1 when more duty lowers the voltage |
| tgt_nom | input | ADC_W | Nominal target code for trim |
| tgt_lo | input | ADC_W | Margin-low target code |
| tgt_hi | input | ADC_W | Margin-high target code |
| deadband | input | ADC_W | Allowed distance from target |
| fixed_duty | input | DUTY_W | Fixed or starting duty |
| margin_req | input | 2 | 0 none, 1 low, 2 high, 3 none |
| adc_code | input | ADC_W | Measured output-voltage code |
| adc_valid | input | 1 | One-cycle strobe for adc_code |
| pwm_out | output | 1 | PWM pin, registered |
| pwm_oe | output | 1 | Pin drive enable, registered |
| settled | output | 1 | Measurement held in band |

## Verification
A sample strobed in one cycle updates the duty command and the settled flag on that same edge. The bench therefore reads settled at the falling edge right after each strobe, and a mode or request change is checked one cycle later. Duty reaches the pin only after the next period boundary plus one output register. The bench waits 260 clocks after the last change and then counts the high cycles over 256 clocks, which compares the observed duty exactly with the value its own model expects. pwm_oe follows mode and request one clock after they change, and the bench samples it two falling edges later.

// File: rtl/vm_pkg.sv
package vm_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_HIZ   = 2'd1,
    MODE_TRIM  = 2'd2,
    MODE_FIXED = 2'd3
  } vm_mode_e;

  typedef enum logic [1:0] {
    REQ_NONE = 2'd0,
    REQ_LOW  = 2'd1,
    REQ_HIGH = 2'd2,
    REQ_RSVD = 2'd3
  } vm_req_e;
endpackage

// File: rtl/vm_policy.sv
module vm_policy
  import vm_pkg::*;
#(
  parameter int ADC_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  vm_mode_e         mode,
  input  vm_req_e          req,
  input  logic [ADC_W-1:0] tgt_nom,
  input  logic [ADC_W-1:0] tgt_lo,
  input  logic [ADC_W-1:0] tgt_hi,
  output logic             regulate,
  output logic             drive_en,
  output logic             cfg_change,
  output logic [ADC_W-1:0] target
);
  vm_mode_e mode_q;
  vm_req_e  req_q;
  logic     margining;

  assign margining = (req == REQ_LOW) || (req == REQ_HIGH);

  always_comb begin
    regulate = 1'b0;
    drive_en = 1'b1;
    case (mode)
      MODE_OFF:  drive_en = 1'b0;
      MODE_HIZ:  begin drive_en = margining; regulate = margining; end
      MODE_TRIM: regulate = 1'b1;
      default:   regulate = margining;
    endcase
  end

  always_comb begin
    case (req)
      REQ_LOW:  target = tgt_lo;
      REQ_HIGH: target = tgt_hi;
      default:  target = tgt_nom;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_OFF;
      req_q  <= REQ_NONE;
    end else begin
      mode_q <= mode;
      req_q  <= req;
    end
  end

  assign cfg_change = (mode != mode_q) || (req != req_q);
endmodule

// File: rtl/vm_servo.sv
module vm_servo #(
  parameter int ADC_W      = 12,
  parameter int DUTY_W     = 8,
  parameter int SETTLE_CNT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regulate,
  input  logic              cfg_change,
  input  logic              invert,
  input  logic [ADC_W-1:0]  target,
  input  logic [ADC_W-1:0]  deadband,
  input  logic [ADC_W-1:0]  adc_code,
  input  logic              adc_valid,
  input  logic [DUTY_W-1:0] fixed_duty,
  output logic [DUTY_W-1:0] duty_q,
  output logic              settled
);
  localparam int CNT_W = $clog2(SETTLE_CNT + 1);
  localparam logic [DUTY_W-1:0] DUTY_MAX = {DUTY_W{1'b1}};
  localparam logic [CNT_W-1:0]  CNT_TOP  = CNT_W'(SETTLE_CNT);

  logic [ADC_W:0]   a_ext, t_ext, d_ext;
  logic             too_high, too_low, in_band, step_up, step_dn;
  logic [CNT_W-1:0] band_cnt;

  assign a_ext    = {1'b0, adc_code};
  assign t_ext    = {1'b0, target};
  assign d_ext    = {1'b0, deadband};
  assign too_high = a_ext > (t_ext + d_ext);
  assign too_low  = (a_ext + d_ext) < t_ext;
  assign in_band  = !too_high && !too_low;
  assign step_up  = invert ? too_high : too_low;
  assign step_dn  = invert ? too_low  : too_high;

  always_ff @(posedge clk) begin
    if (rst) begin
      duty_q <= '0;
    end else if (!regulate) begin
      duty_q <= fixed_duty;
    end else if (adc_valid) begin
      if (step_up && duty_q != DUTY_MAX)  duty_q <= duty_q + 1'b1;
      else if (step_dn && duty_q != '0)   duty_q <= duty_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || cfg_change || !regulate) begin
      band_cnt <= '0;
      settled  <= 1'b0;
    end else if (adc_valid) begin
      if (in_band) begin
        if (band_cnt != CNT_TOP) band_cnt <= band_cnt + 1'b1;
        settled <= (band_cnt + 1'b1) >= CNT_TOP;
      end else begin
        band_cnt <= '0;
        settled  <= 1'b0;
      end
    end
  end

  assert_step_one_R3: assert property (@(posedge clk) disable iff (rst)
    $past(regulate) |-> (duty_q == $past(duty_q) || duty_q == $past(duty_q) + 1'b1 ||
                         duty_q == $past(duty_q) - 1'b1));
  assert_no_step_idle_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(regulate) && !$past(adc_valid)) |-> $stable(duty_q));
  assert_settle_clear_R12: assert property (@(posedge clk) disable iff (rst)
    cfg_change |=> !settled);
  assert_settle_reg_R11: assert property (@(posedge clk) disable iff (rst)
    !regulate |=> !settled);
endmodule

// File: rtl/vm_pwm.sv
module vm_pwm #(
  parameter int DUTY_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              drive_en,
  input  logic [DUTY_W-1:0] duty_cmd,
  output logic              pwm_out,
  output logic              pwm_oe
);
  localparam logic [DUTY_W-1:0] CNT_MAX = {DUTY_W{1'b1}};

  logic [DUTY_W-1:0] cnt, duty_act;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      duty_act <= '0;
      pwm_out  <= 1'b0;
      pwm_oe   <= 1'b0;
    end else begin
      cnt     <= cnt + 1'b1;
      if (cnt == CNT_MAX) duty_act <= duty_cmd;
      pwm_oe  <= drive_en;
      pwm_out <= drive_en && (cnt < duty_act);
    end
  end

  assert_duty_boundary_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(cnt) != CNT_MAX) |-> $stable(duty_act));
  assert_gate_R6: assert property (@(posedge clk) disable iff (rst)
    !pwm_oe |-> !pwm_out);
endmodule

// File: rtl/vmarg_ctrl.sv
module vmarg_ctrl
  import vm_pkg::*;
#(
  parameter int ADC_W      = 12,
  parameter int DUTY_W     = 8,
  parameter int SETTLE_CNT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_invert,
  input  logic [ADC_W-1:0]  tgt_nom,
  input  logic [ADC_W-1:0]  tgt_lo,
  input  logic [ADC_W-1:0]  tgt_hi,
  input  logic [ADC_W-1:0]  deadband,
  input  logic [DUTY_W-1:0] fixed_duty,
  input  logic [1:0]        margin_req,
  input  logic [ADC_W-1:0]  adc_code,
  input  logic              adc_valid,
  output logic              pwm_out,
  output logic              pwm_oe,
  output logic              settled
);
  logic              regulate, drive_en, cfg_change;
  logic [ADC_W-1:0]  target;
  logic [DUTY_W-1:0] duty_cmd;

  vm_policy #(.ADC_W(ADC_W)) u_policy (
    .clk(clk), .rst(rst),
    .mode(vm_mode_e'(cfg_mode)), .req(vm_req_e'(margin_req)),
    .tgt_nom(tgt_nom), .tgt_lo(tgt_lo), .tgt_hi(tgt_hi),
    .regulate(regulate), .drive_en(drive_en),
    .cfg_change(cfg_change), .target(target)
  );

  vm_servo #(.ADC_W(ADC_W), .DUTY_W(DUTY_W), .SETTLE_CNT(SETTLE_CNT)) u_servo (
    .clk(clk), .rst(rst), .regulate(regulate), .cfg_change(cfg_change),
    .invert(cfg_invert), .target(target), .deadband(deadband),
    .adc_code(adc_code), .adc_valid(adc_valid), .fixed_duty(fixed_duty),
    .duty_q(duty_cmd), .settled(settled)
  );

  vm_pwm #(.DUTY_W(DUTY_W)) u_pwm (
    .clk(clk), .rst(rst), .drive_en(drive_en), .duty_cmd(duty_cmd),
    .pwm_out(pwm_out), .pwm_oe(pwm_oe)
  );

  assert_off_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode == 2'd0) |=> (!pwm_oe && !settled));
  assert_hiz_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode == 2'd1 && (margin_req == 2'd0 || margin_req == 2'd3)) |=> !pwm_oe);
  assert_active_drive_R9: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode == 2'd2 || cfg_mode == 2'd3) |=> pwm_oe);
endmodule

// File: tb/tb_vmarg_ctrl.sv
module tb_vmarg_ctrl;
  localparam int ADC_W = 12;
  localparam int DUTY_W = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic [1:0] cfg_mode = 2'd0, margin_req = 2'd0;
  logic cfg_invert = 1'b0, adc_valid = 1'b0;
  logic [ADC_W-1:0] tgt_nom = '0, tgt_lo = '0, tgt_hi = '0, deadband = '0, adc_code = '0;
  logic [DUTY_W-1:0] fixed_duty = '0;
  logic pwm_out, pwm_oe, settled;

  int checks = 0, fails = 0;
  int exp_duty, exp_cnt, hi;
  bit done = 0;

  always #5 clk = ~clk;

  vmarg_ctrl #(.ADC_W(ADC_W), .DUTY_W(DUTY_W), .SETTLE_CNT(4)) dut (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_invert(cfg_invert),
    .tgt_nom(tgt_nom), .tgt_lo(tgt_lo), .tgt_hi(tgt_hi), .deadband(deadband),
    .fixed_duty(fixed_duty), .margin_req(margin_req), .adc_code(adc_code),
    .adc_valid(adc_valid), .pwm_out(pwm_out), .pwm_oe(pwm_oe), .settled(settled)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit band_ok(int code, int tgt, int db);
    return !(code > tgt + db) && !(code + db < tgt);
  endfunction

  function automatic int step_model(int duty, int code, int tgt, int db, bit inv);
    bit low = (code + db < tgt), high = (code > tgt + db);
    bit up = inv ? high : low, dn = inv ? low : high;
    if (up && duty < 255) return duty + 1;
    if (dn && duty > 0) return duty - 1;
    return duty;
  endfunction

  task automatic sample(input int code);
    @(negedge clk); adc_code = ADC_W'(code); adc_valid = 1'b1;
    @(negedge clk); adc_valid = 1'b0;
  endtask

  task automatic settle_wait();
    repeat (3) @(negedge clk);
  endtask

  task automatic measure(output int h);
    repeat (260) @(negedge clk);
    h = 0;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      if (pwm_out) h++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!pwm_oe && !pwm_out && !settled, "R1 reset outputs", {pwm_oe, pwm_out, settled}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!pwm_oe && !pwm_out && !settled, "R1 after release", {pwm_oe, pwm_out, settled}, 0);

    // fixed mode
    cfg_mode = 2'd3; fixed_duty = 8'd64; settle_wait();
    check(pwm_oe, "R9 oe in fixed", pwm_oe, 1);
    measure(hi); check(hi == 64, "R9 R2 fixed duty", hi, 64);
    tgt_nom = 12'd1000; sample(3000); sample(3000);
    measure(hi); check(hi == 64, "R9 samples ignored", hi, 64);
    fixed_duty = 8'd0; measure(hi); check(hi == 0, "R2 duty zero", hi, 0);
    fixed_duty = 8'd255; measure(hi); check(hi == 255, "R2 duty max", hi, 255);

    // high impedance idle
    cfg_mode = 2'd1; fixed_duty = 8'd100; settle_wait();
    check(!pwm_oe && !pwm_out, "R7 hiz idle", pwm_oe, 0);
    margin_req = 2'd3; settle_wait();
    check(!pwm_oe, "R7 reserved request idle", pwm_oe, 0);

    // margin high from tri-state, starts at fixed
    tgt_hi = 12'd2000; deadband = 12'd4; margin_req = 2'd2; settle_wait();
    check(pwm_oe, "R7 oe while margining", pwm_oe, 1);
    repeat (5) sample(1500);
    measure(hi); check(hi == 105, "R3 R10 steps from fixed", hi, 105);
    for (int i = 1; i <= 4; i++) begin
      sample(2003);
      check(settled == (i == 4), "R11 settle count", settled, i == 4);
    end
    measure(hi); check(hi == 105, "R3 deadband holds", hi, 105);
    sample(2010);
    check(!settled, "R11 out of band clears", settled, 0);
    measure(hi); check(hi == 104, "R3 step down above band", hi, 104);
    repeat (4) sample(1998);
    check(settled, "R11 settled again", settled, 1);
    tgt_lo = 12'd1000; margin_req = 2'd1;
    @(negedge clk);
    check(!settled, "R12 request change clears", settled, 0);
    @(negedge clk);
    repeat (3) sample(1200);
    measure(hi); check(hi == 101, "R3 low target", hi, 101);
    cfg_invert = 1'b1; @(negedge clk);
    repeat (2) sample(1200);
    measure(hi); check(hi == 103, "R4 inverted polarity", hi, 103);
    cfg_invert = 1'b0;

    // saturation
    margin_req = 2'd0; fixed_duty = 8'd253; settle_wait();
    margin_req = 2'd2; settle_wait();
    repeat (5) sample(1500);
    measure(hi); check(hi == 255, "R5 saturate high", hi, 255);
    margin_req = 2'd0; fixed_duty = 8'd2; settle_wait();
    margin_req = 2'd1; settle_wait();
    repeat (5) sample(3000);
    measure(hi); check(hi == 0, "R5 saturate low", hi, 0);

    // trim
    margin_req = 2'd0; fixed_duty = 8'd50; settle_wait();
    tgt_nom = 12'd1500; cfg_mode = 2'd2; settle_wait();
    check(pwm_oe, "R8 oe in trim", pwm_oe, 1);
    repeat (3) sample(1400);
    measure(hi); check(hi == 53, "R8 trim to nominal", hi, 53);
    margin_req = 2'd2; settle_wait();
    repeat (2) sample(1000);
    measure(hi); check(hi == 55, "R10 continue from trim", hi, 55);
    repeat (4) sample(2001);
    check(settled, "R11 settled before mode change", settled, 1);
    cfg_mode = 2'd1;
    @(negedge clk);
    check(!settled, "R12 mode change clears", settled, 0);

    // off mode
    cfg_mode = 2'd0; settle_wait();
    repeat (5) sample(2001);
    check(!settled && !pwm_oe, "R6 off ignores", {settled, pwm_oe}, 0);
    hi = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (pwm_out || pwm_oe) hi++;
    end
    check(hi == 0, "R6 no drive in off", hi, 0);

    // constrained random margining
    cfg_mode = 2'd1;
    void'($urandom(32'h5eed));
    for (int it = 0; it < 10; it++) begin
      int tgt, db, code, n;
      bit inv;
      margin_req = 2'd0; fixed_duty = DUTY_W'($urandom_range(0, 255)); settle_wait();
      tgt = $urandom_range(200, 3800); db = $urandom_range(0, 7);
      inv = 1'($urandom_range(0, 1)); n = $urandom_range(1, 20);
      tgt_hi = ADC_W'(tgt); deadband = ADC_W'(db); cfg_invert = inv;
      exp_duty = fixed_duty; exp_cnt = 0;
      margin_req = 2'd2; settle_wait();
      for (int k = 0; k < n; k++) begin
        code = tgt + $urandom_range(0, 30) - 15;
        if ($urandom_range(0, 3) == 0) code = tgt + $urandom_range(0, 2) - 1;
        sample(code);
        exp_duty = step_model(exp_duty, code, tgt, db, inv);
        exp_cnt = band_ok(code, tgt, db) ? ((exp_cnt < 4) ? exp_cnt + 1 : 4) : 0;
        check(settled == (exp_cnt >= 4), "R11 random settle", settled, exp_cnt >= 4);
      end
      measure(hi); check(hi == exp_duty, "R3 R4 R5 random duty", hi, exp_duty);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule